// File: doc/BRIEF.md
# First-Order Pulse-Density DAC Modulator

This block turns an unsigned W-bit level code into a single-bit stream whose long-run fraction of high clocks equals the code divided by a fixed cycle length. Instead of grouping the high clocks into one block at the start of a period, it spreads them evenly in time. This pushes the ripple energy to higher frequencies, so a simple external RC low-pass filter can recover a smooth analog level.

Every clock, the code is added to a W-bit accumulator. The carry out of that addition becomes the output bit for the clock, and dropping the carry also removes one full cycle length from the accumulator at no cost. In binary mode the cycle length is 2^W, so the all-ones code still leaves one low clock in every 2^W. In wrap mode the carry is fed back as the carry-in of the next addition. This makes the cycle length 2^W-1, and the all-ones code then holds the output high on every clock.

Top module: `pdm_dac_top`

## Requirements
- R1: While `rst` is high, `pulse_o` is 0 and the accumulator is cleared, so the stream after reset starts from an empty accumulator.
- R2: In binary mode (MODE = MODE_BINARY), let S be the sum of all codes sampled since reset. After each rising edge, the number of high clocks seen so far equals floor(S / 2^W).
- R3: While the level code is 0, `pulse_o` is 0 from the next clock onward, in either mode.
- R4: A new code is used at the very next rising edge and does not clear the accumulator. The running-sum rules of R2 and R8 therefore hold across code changes.
- R5: While the code has stayed below 2^(W-1) for two consecutive clocks, the output never shows two adjacent high clocks.
- R6: In binary mode with W=8 and the code held at 85 (about one third of full scale), every gap between two high clocks is 2 or 3 low clocks.
- R7: In wrap mode (MODE = MODE_WRAP) with the all-ones code held, `pulse_o` is high on every clock from the second clock after reset onward.
- R8: In wrap mode, with S as in R2 and H the number of high clocks so far, 0 <= S - H*(2^W-1) <= 2^W-1 after each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| level_i | input | W | Unsigned level code sampled every clock |
| pulse_o | output | 1 | Registered pulse-density output bit |

## Verification
The bench drives one code stream into two instances, one per mode. It checks every clock against running sums kept in the bench. A design that lost the accumulator on a code change, or that dropped or doubled an overflow, would drift from floor(S/2^W) within a few clocks. If the carry were not fed back, or were fed back in binary mode, the wrap-mode all-ones code would show periodic low clocks, or the binary stream would carry extra high clocks. Held codes of zero, one third and just under half scale target the three ways a broken adder could fail: a stuck-high output, grouped pulses, or back-to-back highs where they must be spread. A reset in mid-run catches an accumulator that survives reset.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_WRAP   = 1'b1
    } pdm_mode_e;

endpackage

// File: rtl/pdm_dac_adder.sv
module pdm_dac_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int SW = W + 1;

    logic [SW-1:0] wide;

    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, b_i} + {{(SW-1){1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
    end
endmodule

// File: rtl/pdm_dac_top.sv
module pdm_dac_top
    import pdm_dac_pkg::*;
#(
    parameter int        W    = 8,
    parameter pdm_mode_e MODE = MODE_BINARY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_i,
    output logic         pulse_o
);
    localparam logic [W-1:0] HALF     = W'(1) << (W-1);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] acc;
        logic         carry;
        logic         pulse;
    } state_t;

    state_t st_q, st_d;

    logic         cin_sel;
    logic [W-1:0] sum_w;
    logic         cout_w;

    generate
        if (MODE == MODE_WRAP) begin : g_wrap
            assign cin_sel = st_q.carry;
        end else begin : g_binary
            assign cin_sel = 1'b0;
        end
    endgenerate

    pdm_dac_adder #(.W(W)) u_add (
        .a_i    (st_q.acc),
        .b_i    (level_i),
        .cin_i  (cin_sel),
        .sum_o  (sum_w),
        .cout_o (cout_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.acc   = sum_w;
        st_d.carry = cout_w;
        st_d.pulse = cout_w;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R1: reset forces the output low
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !pulse_o);

    // R3: a zero code can never produce an overflow
    a_r3_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (level_i == '0) |=> !pulse_o);

    // R5: codes below half scale never yield two adjacent highs
    a_r5_spread: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && level_i < HALF && $past(level_i) < HALF) |=> !pulse_o);

    // R7: in wrap mode the all-ones code keeps a high output high
    a_r7_full_on: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_WRAP && level_i == ALL_ONES && pulse_o) |=> pulse_o);
endmodule

// File: tb/pdm_dac_top_tb.sv
`timescale 1ns/1ps
module pdm_dac_top_tb;
    import pdm_dac_pkg::*;

    localparam int W = 8;
    localparam longint NB = 256;
    localparam longint NW = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] level = '0;
    logic pulse_b, pulse_w;

    int n_tests = 0;
    int n_fail  = 0;
    longint s_sum = 0;
    longint ones_b = 0;
    longint ones_w = 0;
    int done = 0;

    always #2 clk = ~clk;

    pdm_dac_top #(.W(W), .MODE(MODE_BINARY)) u_dut (
        .clk(clk), .rst(rst), .level_i(level), .pulse_o(pulse_b));
    pdm_dac_top #(.W(W), .MODE(MODE_WRAP)) u_dut_wrap (
        .clk(clk), .rst(rst), .level_i(level), .pulse_o(pulse_w));

    function automatic longint exp_ones_b(input longint s);
        return s / NB;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        level = 8'd200;
        @(negedge clk);
        check("R1 binary out in reset", longint'(pulse_b), 0);
        check("R1 wrap out in reset", longint'(pulse_w), 0);
        rst = 1'b0;
        s_sum = 0; ones_b = 0; ones_w = 0;
    endtask

    // drive one code, advance one clock, check running sums (R2, R4, R8)
    task automatic step(input logic [W-1:0] k, output logic ob, output logic ow);
        longint r;
        level = k;
        s_sum += k;
        @(negedge clk);
        ob = pulse_b; ow = pulse_w;
        ones_b += pulse_b;
        ones_w += pulse_w;
        check("R2 R4 binary ones count", ones_b, exp_ones_b(s_sum));
        r = s_sum - ones_w * NW;
        check("R8 wrap residue in range", longint'(r >= 0 && r <= NW), 1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic ob, ow;
        int seed;
        seed = 1234;
        void'($urandom(seed));
        do_reset();

        // R7: all-ones in wrap mode goes and stays high from clock 2
        for (int i = 0; i < 40; i++) begin
            step(8'hFF, ob, ow);
            if (i >= 1) check("R7 wrap all-ones high", longint'(ow), 1);
        end

        // R3: zero code silences both
        for (int i = 0; i < 30; i++) begin
            step(8'h00, ob, ow);
            check("R3 binary zero", longint'(ob), 0);
            check("R3 wrap zero", longint'(ow), 0);
        end

        // R6: one-third code gives gaps of 2 or 3 lows
        begin
            int gap; bit seen;
            gap = 0; seen = 0;
            for (int i = 0; i < 400; i++) begin
                step(8'd85, ob, ow);
                if (ob) begin
                    if (seen) check("R6 gap 2 or 3", longint'(gap == 2 || gap == 3), 1);
                    seen = 1; gap = 0;
                end else gap++;
            end
        end

        // R5: just under half scale never gives adjacent highs
        begin
            logic prev_b, prev_w;
            prev_b = 0; prev_w = 0;
            for (int i = 0; i < 200; i++) begin
                step(8'd127, ob, ow);
                if (i >= 1) begin
                    check("R5 binary spread", longint'(ob && prev_b), 0);
                    check("R5 wrap spread", longint'(ow && prev_w), 0);
                end
                prev_b = ob; prev_w = ow;
            end
        end

        // R2 R4 R8: random codes with frequent changes
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] k;
            k = W'($urandom_range(0, 255));
            if (i % 7 == 0) k = 8'hFF;
            step(k, ob, ow);
        end

        // R1: reset mid-run clears accumulator; a fresh stream matches from zero
        do_reset();
        for (int i = 0; i < 600; i++) begin
            step(W'($urandom_range(0, 255)), ob, ow);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule